// File: doc/BRIEF.md
# Compare-Match Event Timer

A single timer channel that counts ticks of a 32768 Hz slow clock, supplied as a one-cycle `tick` enable in the fast `clk` domain, and raises an event when the count reaches a programmable compare value. Software programs a compare value, picks a mode and issues a start-and-restart command. In one-shot mode the channel stops at the match, which gives delays of 1 to 65535 ticks (up to about two seconds). In periodic mode it wraps to zero at the match and keeps running. For a periodic event rate `f`, the compare value is (32768 + f/2) / f. For example, 100 Hz uses 328.

A small register file is reached through a one-cycle write strobe and a one-cycle read strobe, both sharing a 3-bit address. It holds the mode, the compare value, a command port, set-bit and clear-bit ports for the interrupt mask, a readable mask, a status word that clears on read, and the live count. The interrupt output is high while the match flag is set and bit 0 of the mask is set.

Top module: `cmt_timer`

## Requirements
- R1: After reset the count, the compare value, the mode, the mask and the match flag are all zero, the channel is stopped and `irq` is low.
- R2: Address 2 (command) takes bit 0 = start, bit 1 = halt, bit 2 = restart. Restart clears the count to zero in that cycle. While running, the count advances by one only in cycles where `tick` is high.
- R3: Let N be the value held at address 1 (compare). The tick that would take the count to N sets the match flag, which reads as bit 0 of status (address 6). Status bit 8 reads as the running state.
- R4: When mode bit 0 (stop-at-match, address 0) is set, the matching tick stops the channel. The count stays at N.
- R5: When mode bit 1 (wrap-at-match) is set, the matching tick loads zero and the channel keeps running. Matches then recur every N ticks. With neither mode bit set, the count takes the value N and keeps counting.
- R6: A command with halt set stops counting, and halt takes priority over start when both are in the same write.
- R7: A write to address 3 sets the mask bits given by 1s in the data. A write to address 4 clears the mask bits given by 1s (0xFF clears all). Address 5 reads the 8-bit mask. `irq` equals the match flag AND mask bit 0.
- R8: A status read returns the flags and then clears the match flag, which lowers `irq`. A match in the same cycle as the read leaves the flag set.
- R9: A compare write while running is used at the very next tick evaluation.
- R10: A restart in the same cycle as a matching tick wins: the count becomes zero and the flag is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse per slow-clock period |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (status read clears flag) |
| addr | input | 3 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr`, valid while `rd_en` is high |
| irq | output | 1 | Interrupt request |

## Verification
The hardest cases are collisions in a single clock cycle: a status read that lands on the same tick that produces a match, and a restart command that lands on a matching tick. The stimulus first counts the channel up to one tick short of the compare value with plain ticks. It then issues a write or read that carries `tick` in the same cycle, and follows with status and count reads to see which action won. A compare value rewritten mid-count is also placed so that the old value is passed without a match.

// File: rtl/cmt_timer.sv
module cmt_timer #(
  parameter int CW = 16,
  parameter int MW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [2:0]    addr,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] rdata,
  output logic          irq
);
  localparam logic [2:0] A_MODE = 3'd0, A_CMP = 3'd1, A_CMD = 3'd2, A_IEN = 3'd3,
                         A_IDIS = 3'd4, A_MASK = 3'd5, A_STAT = 3'd6, A_CNT = 3'd7;

  logic [CW-1:0] count_q, cmp_q;
  logic [1:0]    mode_q;
  logic [MW-1:0] mask_q;
  logic          run_q, flag_q;

  wire cmd_wr  = wr_en && addr == A_CMD;
  wire restart = cmd_wr && wdata[2];
  wire step    = tick && run_q && !restart;
  wire [CW-1:0] nxt = count_q + 1'b1;
  wire hit     = step && nxt == cmp_q;
  wire stat_rd = rd_en && addr == A_STAT;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
      cmp_q   <= '0;
      mode_q  <= '0;
      mask_q  <= '0;
      run_q   <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      if (restart)
        count_q <= '0;
      else if (step)
        count_q <= (hit && mode_q[1]) ? '0 : nxt;

      if (cmd_wr && wdata[1])
        run_q <= 1'b0;
      else if (cmd_wr && wdata[0])
        run_q <= 1'b1;
      else if (hit && mode_q[0])
        run_q <= 1'b0;

      if (hit)
        flag_q <= 1'b1;
      else if (stat_rd)
        flag_q <= 1'b0;

      if (wr_en) begin
        case (addr)
          A_MODE: mode_q <= wdata[1:0];
          A_CMP:  cmp_q  <= wdata;
          A_IEN:  mask_q <= mask_q | wdata[MW-1:0];
          A_IDIS: mask_q <= mask_q & ~wdata[MW-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr)
        A_MODE: rdata[1:0]    = mode_q;
        A_CMP:  rdata         = cmp_q;
        A_MASK: rdata[MW-1:0] = mask_q;
        A_STAT: begin
          rdata[0] = flag_q;
          rdata[8] = run_q;
        end
        A_CNT:  rdata         = count_q;
        default: ;
      endcase
    end
  end

  assign irq = flag_q & mask_q[0];
endmodule

module cmt_timer_chk #(
  parameter int CW = 16,
  parameter int MW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          wr_en,
  input logic [2:0]    addr,
  input logic [CW-1:0] wdata,
  input logic [CW-1:0] count,
  input logic [CW-1:0] cmp,
  input logic [1:0]    mode,
  input logic          running,
  input logic          flag,
  input logic          irq
);
  wire cmdw = wr_en && addr == 3'd2;
  wire [CW-1:0] inc = count + 1'b1;

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cmdw) |=> $stable(count)); // R2
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && running && !cmdw && inc != cmp) |=> count == $past(count) + 1'b1); // R2
  AST_MATCH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && running && !cmdw && inc == cmp) |=> flag); // R3
  AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && running && !cmdw && inc == cmp && mode[0]) |=> !running); // R4
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && running && !cmdw && inc == cmp && mode[1]) |=> count == '0); // R5
  AST_HALT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdw && wdata[1]) |=> !running); // R6
  AST_MASK_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd4 && wdata[0]) |=> !irq); // R7
  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdw && wdata[2]) |=> count == '0); // R10
endmodule

bind cmt_timer cmt_timer_chk #(.CW(CW), .MW(MW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .count(count_q), .cmp(cmp_q), .mode(mode_q), .running(run_q), .flag(flag_q), .irq(irq)
);

// File: tb/tb_cmt_timer.sv
module tb_cmt_timer;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic irq;
  int checks = 0, failures = 0;

  typedef struct { logic [15:0] exp; int req; logic [2:0] a; } item_t;
  item_t sbq[$];

  cmt_timer dut (.clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
                 .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  always #2 clk = ~clk;

  always @(posedge clk) if (rd_en) begin
    item_t it;
    if (sbq.size() == 0) begin
      failures++;
      $display("FAIL R%0d: unexpected read, actual %h expected none", 0, rdata);
    end else begin
      it = sbq.pop_front();
      checks++;
      if (rdata !== it.exp) begin
        failures++;
        $display("FAIL R%0d: addr %0d actual %h expected %h", it.req, it.a, rdata, it.exp);
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d, input logic t = 1'b0);
    wr_en = 1'b1; addr = a; wdata = d; tick = t;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [15:0] e, input int r, input logic t = 1'b0);
    item_t it;
    it.exp = e; it.req = r; it.a = a;
    sbq.push_back(it);
    rd_en = 1'b1; addr = a; tick = t;
    @(negedge clk);
    rd_en = 1'b0; tick = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1; @(negedge clk);
      tick = 1'b0; @(negedge clk);
    end
  endtask

  task automatic chk_irq(input logic e, input int r);
    checks++;
    if (irq !== e) begin
      failures++;
      $display("FAIL R%0d: irq actual %b expected %b", r, irq, e);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(3'd7, 16'h0000, 1); rd(3'd6, 16'h0000, 1); rd(3'd5, 16'h0000, 1);
    rd(3'd1, 16'h0000, 1); chk_irq(1'b0, 1);
    // R2 start+restart, count per tick
    wr(3'd1, 16'd10); wr(3'd0, 16'd0); wr(3'd2, 16'b101);
    ticks(3); rd(3'd7, 16'd3, 2);
    repeat (4) @(negedge clk);
    rd(3'd7, 16'd3, 2);
    // R6 halt, halt beats start
    wr(3'd2, 16'b010); ticks(2); rd(3'd7, 16'd3, 6);
    wr(3'd2, 16'b011); ticks(1); rd(3'd7, 16'd3, 6);
    wr(3'd2, 16'b001); ticks(1); rd(3'd7, 16'd4, 6);
    // R3 match in free mode, R8 clear on read
    ticks(5); rd(3'd6, 16'h0100, 3);
    ticks(1); rd(3'd6, 16'h0101, 3); rd(3'd6, 16'h0100, 8);
    rd(3'd7, 16'd10, 5);
    // R4 one-shot
    wr(3'd0, 16'd1); wr(3'd1, 16'd4); wr(3'd2, 16'b101);
    ticks(4); rd(3'd6, 16'h0001, 4); ticks(2); rd(3'd7, 16'd4, 4);
    // R5 periodic
    wr(3'd0, 16'd2); wr(3'd1, 16'd3); wr(3'd2, 16'b101);
    ticks(3); rd(3'd7, 16'd0, 5); rd(3'd6, 16'h0101, 5);
    ticks(3); rd(3'd6, 16'h0101, 5); ticks(1); rd(3'd7, 16'd1, 5);
    // R7 mask set/clear and irq
    wr(3'd3, 16'h0001); rd(3'd5, 16'h0001, 7);
    ticks(2); chk_irq(1'b1, 7);
    wr(3'd3, 16'h0080); rd(3'd5, 16'h0081, 7);
    wr(3'd4, 16'h0001); rd(3'd5, 16'h0080, 7); chk_irq(1'b0, 7);
    wr(3'd3, 16'h0001); chk_irq(1'b1, 7);
    wr(3'd4, 16'h00FF); rd(3'd5, 16'h0000, 7); chk_irq(1'b0, 7);
    // R8 read clears irq; match in same cycle as read wins
    wr(3'd3, 16'h0001); chk_irq(1'b1, 8);
    rd(3'd6, 16'h0101, 8); chk_irq(1'b0, 8);
    ticks(2); rd(3'd7, 16'd2, 8);
    rd(3'd6, 16'h0100, 8, 1'b1); chk_irq(1'b1, 8);
    rd(3'd6, 16'h0101, 8); rd(3'd7, 16'd0, 8);
    // R9 compare change while running
    ticks(1); wr(3'd1, 16'd6); ticks(4);
    rd(3'd6, 16'h0100, 9); rd(3'd7, 16'd5, 9);
    ticks(1); rd(3'd6, 16'h0101, 9); rd(3'd7, 16'd0, 9);
    // R10 restart beats match
    ticks(5); rd(3'd7, 16'd5, 10);
    wr(3'd2, 16'b101, 1'b1);
    rd(3'd6, 16'h0100, 10); rd(3'd7, 16'd0, 10); chk_irq(1'b0, 10);
    @(negedge clk);
    if (sbq.size() != 0) begin
      failures++;
      $display("FAIL R0: pending reads actual %0d expected 0", sbq.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule